// File: doc/BRIEF.md
# Quad-Span Line Card Control Register Block

This block is the small control register file of a line card that carries four T1/E1 spans. It sits on a byte-wide local bus behind a host bridge. It holds the clock-source selection, the line mode, the two loopback controls, the per-span status lamps and two test pins. It also merges a periodic frame interrupt with the framer device's own interrupt to drive a single host interrupt line.

The local bus carries an 11-bit address, separate read and write strobes and 8-bit data. Register writes take effect on the clock edge that samples the strobe. Read data is registered and appears in the cycle after the read strobe. The four 256-byte framer windows at the bottom of the address space are not decoded here. The block only raises a one-hot transceiver select while an access falls into one of them.

The internal interrupt is set by a one-cycle frame tick and is held until software acknowledges it. The framer interrupt input is active low. It passes through a two-flop synchronizer before it is used.

Top module: `spanctl_regs`

## Requirements
- R1: After a synchronous active-low reset, all outputs are 0: `sync_src`=0 (free run, so `sync_onehot`=5'b00001), no loopback, T1 mode, LEDs off, test pins low, `host_irq` low, `bus_rdata`=0.
- R2: A write of value v to address 0x400 sets `sync_src` to v when v is 0 to 4 (0 = free run, n = span n recovered clock) and leaves it unchanged when v is 5 to 255. `sync_onehot` has exactly bit `sync_src` set. Both take effect after the write edge.
- R3: A write to address 0x401 stores the control bits: bit0 interrupt enable, bit1 `test1`, bit2 framer-interrupt gate, bit3 `master_sync_en`, bit4 `e1_mode` (1 = E1 divisor, 0 = T1), bit5 `remote_loop`, bit6 `local_loop`.
- R4: Bit 7 of a control write is an acknowledge that clears the pending internal interrupt. It is not stored, and a later frame tick sets the interrupt again.
- R5: A `frame_tick` pulse sets the pending internal interrupt, which stays set until acknowledged. A tick in the same cycle as an acknowledge leaves it set.
- R6: `framer_irq_n` is active low and reaches the status and gating logic two clock edges after it changes.
- R7: `host_irq` = interrupt enable AND (pending internal interrupt OR (synchronized framer interrupt AND gate)).
- R8: A read of 0x400 returns status in the next cycle: bit0 interrupt enable, bit1 internal pending, bit2 synchronized framer interrupt, bits 7:3 zero.
- R9: A write to 0x402 sets `led`. Span k (1 to 4) uses bit 2(k-1) for green and bit 2(k-1)+1 for red. Both bits set show yellow.
- R10: Bit 0 of a write to 0x403 drives `test2`. Bit 0 of a write to 0x404 drives `newrev_mode`. The other bits of these writes are ignored.
- R11: Reads of 0x401 to 0x404 (write-only) and of 0x405 to 0x7FF return 0. Writes to 0x405 to 0x7FF change nothing.
- R12: While a read or write strobe is high and the address is below 0x400, `xcvr_sel` bit `addr[9:8]` is high and no register changes. Otherwise `xcvr_sel` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 11 | Local bus byte address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| xcvr_sel | output | 4 | One-hot framer window select |
| frame_tick | input | 1 | One-cycle periodic interrupt source |
| framer_irq_n | input | 1 | Framer interrupt, active low, asynchronous |
| host_irq | output | 1 | Host interrupt request, active high |
| sync_src | output | 3 | Clock source code, 0 = free run, 1 to 4 = span |
| sync_onehot | output | 5 | One-hot form of `sync_src` |
| master_sync_en | output | 1 | External master sync enable |
| e1_mode | output | 1 | 1 selects the E1 divisor, 0 the T1 divisor |
| remote_loop | output | 1 | Transmit serial data taken from receive serial data |
| local_loop | output | 1 | Receive buffers fed from transmit buffers |
| led | output | 8 | Green/red lamp pair per span |
| test1 | output | 1 | First test pin |
| test2 | output | 1 | Second test pin |
| newrev_mode | output | 1 | Selects the later framer revision mode |

## Verification
The checker watches on every cycle that a tick always leaves the internal interrupt pending and that an acknowledge without a tick clears it. It also watches that the host line stays low while interrupts are disabled, that the clock-source code never leaves 0 to 4, that the framer interrupt lags the pin by exactly two edges, and that the transceiver select stays one-hot and idle for register accesses. The bench's sweeps cover the rest: the decoded meaning of every control, lamp and test bit, the status layout, the full combination table of enable, gate, pending and framer inputs behind the host line, the tick-versus-acknowledge collision, and the zero reads and ignored writes across the unused addresses.

// File: rtl/spanctl_pkg.sv
// Shared types for the span control register block.
// Assumes an 8-bit local data bus; the control layout below is decoded
// bit-for-bit from the control write data.
package spanctl_pkg;

    // Stored control bits; packed MSB first so a cast of wdata[6:0] lines up.
    typedef struct packed {
        logic local_loop;   // bit 6
        logic remote_loop;  // bit 5
        logic e1_mode;      // bit 4
        logic master_sync;  // bit 3
        logic fr_gate;      // bit 2
        logic test1;        // bit 1
        logic irq_en;       // bit 0
    } ctl_t;

    localparam int CTL_W   = $bits(ctl_t);
    localparam int ACK_BIT = 7;

endpackage

// File: rtl/spanctl_sync.sv
// Multi-stage synchronizer for one asynchronous input.
// Assumes the input is a level with no protocol; every stage resets to
// IDLE_VAL so the output reads idle right after reset.
module spanctl_sync #(
    parameter int   STAGES   = 2,
    parameter logic IDLE_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the input through the stage chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= {STAGES{IDLE_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spanctl_irq.sv
// Interrupt combiner: holds the internal pending flag and forms the host
// interrupt line. Assumes tick and ack are single-cycle, synchronous strobes
// and fr_active is already synchronized.
module spanctl_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic ack,
    input  logic irq_en,
    input  logic fr_gate,
    input  logic fr_active,
    output logic pend,
    output logic host_irq
);
    // Set on tick, clear on ack; a tick in the same cycle wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (tick) begin
            pend <= 1'b1;
        end else if (ack) begin
            pend <= 1'b0;
        end
    end

    // Host line: enable gates both the internal and gated framer sources.
    always_comb begin
        host_irq = irq_en & (pend | (fr_active & fr_gate));
    end
endmodule

// File: rtl/spanctl_regfile.sv
// Register file for the span control block: decodes writes to the register
// window, produces the acknowledge strobe and the registered read data.
// Assumes the register window starts at BASE and is five bytes long.
module spanctl_regfile
    import spanctl_pkg::*;
#(
    parameter int          ADDR_W    = 11,
    parameter int          NUM_SPANS = 4,
    parameter int          SEL_W     = 3,
    parameter int          LED_W     = 8,
    parameter logic [10:0] BASE      = 11'h400
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    input  logic [7:0]        wdata,
    input  logic              pend,
    input  logic              fr_active,
    output ctl_t              ctl_q,
    output logic [SEL_W-1:0]  sync_q,
    output logic [LED_W-1:0]  led_q,
    output logic              test2_q,
    output logic              newrev_q,
    output logic              ack,
    output logic [7:0]        rdata
);
    localparam logic [ADDR_W-1:0] OFS_SYNC  = ADDR_W'(BASE);
    localparam logic [ADDR_W-1:0] OFS_CTL   = ADDR_W'(BASE + 11'd1);
    localparam logic [ADDR_W-1:0] OFS_LED   = ADDR_W'(BASE + 11'd2);
    localparam logic [ADDR_W-1:0] OFS_TEST  = ADDR_W'(BASE + 11'd3);
    localparam logic [ADDR_W-1:0] OFS_REV   = ADDR_W'(BASE + 11'd4);
    localparam logic [7:0]        MAX_SEL   = 8'(NUM_SPANS);

    // Register writes; out-of-range source codes are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q    <= '0;
            sync_q   <= '0;
            led_q    <= '0;
            test2_q  <= 1'b0;
            newrev_q <= 1'b0;
        end else if (wr) begin
            case (addr)
                OFS_SYNC: if (wdata <= MAX_SEL) sync_q <= wdata[SEL_W-1:0];
                OFS_CTL:  ctl_q    <= ctl_t'(wdata[CTL_W-1:0]);
                OFS_LED:  led_q    <= wdata[LED_W-1:0];
                OFS_TEST: test2_q  <= wdata[0];
                OFS_REV:  newrev_q <= wdata[0];
                default:  ;
            endcase
        end
    end

    // Acknowledge strobe from the self-clearing control bit.
    always_comb begin
        ack = wr && (addr == OFS_CTL) && wdata[ACK_BIT];
    end

    // Registered read data; only the status address returns non-zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd && (addr == OFS_SYNC)) begin
            rdata <= {5'b0, fr_active, pend, ctl_q.irq_en};
        end else begin
            rdata <= '0;
        end
    end
endmodule

// File: rtl/spanctl_regs.sv
// Top of the span control register block: register file, interrupt
// combiner, framer interrupt synchronizer and the framer window select.
// Assumes one clock domain for the bus; only framer_irq_n is asynchronous.
module spanctl_regs
    import spanctl_pkg::*;
#(
    parameter int          NUM_SPANS   = 4,
    parameter int          SYNC_STAGES = 2,
    parameter int          WIN_BITS    = 8,
    parameter logic [10:0] BASE        = 11'h400,
    localparam int         ADDR_W      = 11,
    localparam int         SEL_W       = $clog2(NUM_SPANS + 1),
    localparam int         LED_W       = 2 * NUM_SPANS,
    localparam int         IDX_W       = $clog2(NUM_SPANS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NUM_SPANS-1:0] xcvr_sel,
    input  logic              frame_tick,
    input  logic              framer_irq_n,
    output logic              host_irq,
    output logic [SEL_W-1:0]  sync_src,
    output logic [NUM_SPANS:0] sync_onehot,
    output logic              master_sync_en,
    output logic              e1_mode,
    output logic              remote_loop,
    output logic              local_loop,
    output logic [LED_W-1:0]  led,
    output logic              test1,
    output logic              test2,
    output logic              newrev_mode
);
    localparam logic [ADDR_W-1:0] WIN_END = ADDR_W'(NUM_SPANS << WIN_BITS);

    ctl_t ctl_q;
    logic pend;
    logic ack;
    logic fr_sync_n;
    logic fr_active;
    logic in_win;

    spanctl_sync #(.STAGES(SYNC_STAGES), .IDLE_VAL(1'b1)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (framer_irq_n),
        .q     (fr_sync_n)
    );
    assign fr_active = ~fr_sync_n;

    spanctl_regfile #(
        .ADDR_W(ADDR_W), .NUM_SPANS(NUM_SPANS), .SEL_W(SEL_W),
        .LED_W(LED_W), .BASE(BASE)
    ) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .addr      (bus_addr),
        .wr        (bus_wr),
        .rd        (bus_rd),
        .wdata     (bus_wdata),
        .pend      (pend),
        .fr_active (fr_active),
        .ctl_q     (ctl_q),
        .sync_q    (sync_src),
        .led_q     (led),
        .test2_q   (test2),
        .newrev_q  (newrev_mode),
        .ack       (ack),
        .rdata     (bus_rdata)
    );

    spanctl_irq i_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (frame_tick),
        .ack       (ack),
        .irq_en    (ctl_q.irq_en),
        .fr_gate   (ctl_q.fr_gate),
        .fr_active (fr_active),
        .pend      (pend),
        .host_irq  (host_irq)
    );

    // Control fields out to the pins.
    always_comb begin
        master_sync_en = ctl_q.master_sync;
        e1_mode        = ctl_q.e1_mode;
        remote_loop    = ctl_q.remote_loop;
        local_loop     = ctl_q.local_loop;
        test1          = ctl_q.test1;
    end

    // Access falls in the framer windows below the register base.
    always_comb begin
        in_win = (bus_wr || bus_rd) && (bus_addr < WIN_END);
    end

    // One select per framer window, one one-hot bit per clock source.
    for (genvar i = 0; i < NUM_SPANS; i++) begin : g_xsel
        assign xcvr_sel[i] = in_win && (bus_addr[WIN_BITS +: IDX_W] == IDX_W'(i));
    end
    for (genvar s = 0; s <= NUM_SPANS; s++) begin : g_src
        assign sync_onehot[s] = (sync_src == SEL_W'(s));
    end
endmodule

// File: rtl/spanctl_regs_chk.sv
// Cycle checker for spanctl_regs, attached by bind below. Observes only
// ports and the pending flag; assumes the default register base.
module spanctl_regs_chk #(
    parameter logic [10:0] BASE = 11'h400
) (
    input logic        clk,
    input logic        rst_n,
    input logic [10:0] bus_addr,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_wdata,
    input logic [7:0]  bus_rdata,
    input logic [3:0]  xcvr_sel,
    input logic        frame_tick,
    input logic        framer_irq_n,
    input logic        host_irq,
    input logic        irq_en,
    input logic [2:0]  sync_src,
    input logic        pend,
    input logic        fr_active
);
    logic [1:0] up_cnt;

    // Count cycles since reset, saturating at two.
    always_ff @(posedge clk) begin
        if (!rst_n) up_cnt <= 2'd0;
        else if (up_cnt != 2'd2) up_cnt <= up_cnt + 2'd1;
    end

    a_r5_tick_sets: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> pend);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE + 11'd1 && bus_wdata[7] && !frame_tick) |=> !pend);
    a_r7_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !host_irq);
    a_r7_pending_raises: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_en && pend) |-> host_irq);
    a_r2_src_range: assert property (@(posedge clk) disable iff (!rst_n)
        sync_src <= 3'd4);
    a_r2_bad_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == BASE && bus_wdata > 8'd4) |=> $stable(sync_src));
    a_r6_sync_lag: assert property (@(posedge clk) disable iff (!rst_n)
        (up_cnt == 2'd2) |-> (fr_active == !$past(framer_irq_n, 2)));
    a_r12_sel_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(xcvr_sel));
    a_r12_sel_idle_regs: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && bus_addr >= BASE) |-> (xcvr_sel == 4'd0));
    a_r11_wo_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr > BASE) |=> (bus_rdata == 8'd0));
endmodule

bind spanctl_regs spanctl_regs_chk #(.BASE(11'h400)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_addr     (bus_addr),
    .bus_wr       (bus_wr),
    .bus_rd       (bus_rd),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .xcvr_sel     (xcvr_sel),
    .frame_tick   (frame_tick),
    .framer_irq_n (framer_irq_n),
    .host_irq     (host_irq),
    .irq_en       (ctl_q.irq_en),
    .sync_src     (sync_src),
    .pend         (pend),
    .fr_active    (fr_active)
);

// File: tb/test_spanctl_regs.sv
// Sweep bench for spanctl_regs: drives at falling edges, samples at the
// falling edge after the capturing rising edge.
module test_spanctl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [3:0]  xcvr_sel;
    logic        frame_tick = 1'b0;
    logic        framer_irq_n = 1'b1;
    logic        host_irq;
    logic [2:0]  sync_src;
    logic [4:0]  sync_onehot;
    logic        master_sync_en, e1_mode, remote_loop, local_loop;
    logic [7:0]  led;
    logic        test1, test2, newrev_mode;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    spanctl_regs i_spanctl_regs (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [10:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic tick();
        @(negedge clk); frame_tick = 1'b1;
        @(negedge clk); frame_tick = 1'b0;
    endtask

    // All visible outputs packed for unchanged-state comparisons.
    function automatic logic [31:0] outs();
        return {7'b0, sync_src, led, test2, newrev_mode, test1, master_sync_en,
                e1_mode, remote_loop, local_loop, host_irq, sync_onehot, 3'b0};
    endfunction

    initial begin : wdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [7:0] d;
        logic [2:0] prev;
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 sync_src", sync_src, 0);
        chk("R1 sync_onehot", sync_onehot, 5'b00001);
        chk("R1 ctl outs", {master_sync_en, e1_mode, remote_loop, local_loop, test1}, 0);
        chk("R1 led/test", {led, test2, newrev_mode}, 0);
        chk("R1 host_irq", host_irq, 0);
        chk("R1 rdata", bus_rdata, 0);

        // R2 sweep all codes twice, checking kept value on bad codes
        prev = 3'd0;
        for (int pass = 0; pass < 2; pass++) begin
            for (int v = 0; v < 256; v += (v < 8 ? 1 : 37)) begin
                int vv;
                vv = (pass == 0) ? v : ((v + 3) % 256);
                wr(11'h400, 8'(vv));
                if (vv <= 4) prev = 3'(vv);
                chk("R2 sync_src", sync_src, prev);
                chk("R2 sync_onehot", sync_onehot, 5'(1) << prev);
            end
        end

        // R3 control sweep over all stored bit patterns
        for (int v = 0; v < 128; v++) begin
            wr(11'h401, 8'(v));
            chk("R3 test1", test1, (v >> 1) & 1);
            chk("R3 master_sync_en", master_sync_en, (v >> 3) & 1);
            chk("R3 e1_mode", e1_mode, (v >> 4) & 1);
            chk("R3 remote_loop", remote_loop, (v >> 5) & 1);
            chk("R3 local_loop", local_loop, (v >> 6) & 1);
            rd(11'h400, d);
            chk("R3 R8 irq_en in status", d[0], v & 1);
        end

        // R9 lamp sweep
        for (int v = 0; v < 256; v++) begin
            wr(11'h402, 8'(v));
            for (int k = 0; k < 4; k++) begin
                chk("R9 green", led[2*k], (v >> (2*k)) & 1);
                chk("R9 red", led[2*k+1], (v >> (2*k+1)) & 1);
            end
        end

        // R10 test pin and revision mode; upper bits ignored
        for (int v = 0; v < 256; v += 5) begin
            wr(11'h403, 8'(v));
            chk("R10 test2", test2, v & 1);
            wr(11'h404, 8'(v ^ 8'h5A));
            chk("R10 newrev_mode", newrev_mode, (v ^ 8'h5A) & 1);
        end

        // R7 R5 R6 R8 interrupt combination table
        for (int c = 0; c < 16; c++) begin
            logic ie, gate, pnd, fint;
            ie = c[0]; gate = c[1]; pnd = c[2]; fint = c[3];
            wr(11'h401, {1'b1, 4'b0, gate, 1'b0, ie});
            framer_irq_n = ~fint;
            repeat (3) @(negedge clk);
            if (pnd) tick();
            chk("R7 host_irq", host_irq, ie & (pnd | (fint & gate)));
            rd(11'h400, d);
            chk("R8 status", d, {5'b0, fint, pnd, ie});
        end
        framer_irq_n = 1'b1;

        // R6 two-edge lag through the synchronizer
        wr(11'h401, 8'b1000_0101);
        repeat (3) @(negedge clk);
        framer_irq_n = 1'b0;
        @(negedge clk);
        chk("R6 one edge: not yet", host_irq, 0);
        @(negedge clk);
        chk("R6 two edges: active", host_irq, 1);
        framer_irq_n = 1'b1;
        @(negedge clk);
        chk("R6 release one edge: still", host_irq, 1);
        @(negedge clk);
        chk("R6 release two edges: clear", host_irq, 0);

        // R4 R5 acknowledge, hold and re-arm
        wr(11'h401, 8'b0000_0001);
        tick();
        repeat (4) @(negedge clk);
        chk("R5 pending held", host_irq, 1);
        wr(11'h401, 8'b1000_0001);
        chk("R4 ack clears", host_irq, 0);
        rd(11'h400, d);
        chk("R4 ack not stored, status", d, 8'h01);
        tick();
        chk("R4 re-arms after ack", host_irq, 1);
        // R5 tick in the same cycle as ack wins
        @(negedge clk);
        bus_addr = 11'h401; bus_wdata = 8'b1000_0001; bus_wr = 1'b1; frame_tick = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; frame_tick = 1'b0;
        chk("R5 tick beats ack", host_irq, 1);
        wr(11'h401, 8'b1000_0000);

        // R11 write-only and unmapped reads are zero; unmapped writes ignored
        wr(11'h401, 8'h7F); tick();
        for (int a = 11'h401; a < 11'h800; a += (a < 11'h410 ? 1 : 97)) begin
            rd(11'(a), d);
            chk("R11 read zero", d, 0);
        end
        snap = outs();
        for (int a = 11'h405; a < 11'h800; a += 61) begin
            wr(11'(a), 8'hFF);
            wr(11'(a), 8'h00);
        end
        chk("R11 unmapped writes ignored", outs(), snap);

        // R12 window select and no register effect
        for (int a = 0; a < 11'h800; a += 53) begin
            @(negedge clk);
            bus_addr = 11'(a); bus_rd = 1'b1;
            #1;
            chk("R12 xcvr_sel", xcvr_sel, (a < 11'h400) ? (4'b1 << (a >> 8)) : 4'b0);
            bus_rd = 1'b0;
            #1;
            chk("R12 idle without strobe", xcvr_sel, 0);
        end
        snap = outs();
        for (int a = 0; a < 11'h400; a += 129) wr(11'(a), 8'(a ^ 8'hC3));
        chk("R12 window writes ignored", outs(), snap);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule